// File: doc/BRIEF.md
# Programmable Synthesizer Divider Chain

This block holds the digital dividers that sit around a phase-locked loop. The crystal clock is divided by a fixed power-of-two ratio (16 by default) to form the phase-detector reference. A programmable divider on the VCO clock, followed by a toggle stage, forms the feedback clock, so a locked loop runs the VCO at 2·M times the reference. A third divider on the VCO clock forms the synthesizer output, picked by a 2-bit code. The analogue parts of the loop (phase detector, charge pump, VCO) live outside; the VCO clock enters here as a fast digital clock.

A 3-bit select routes one of eight internal signals to a test pin. The choices include the reference, the halved feedback, the output and a quarter-rate output. One choice runs a second copy of the M divider from the serial clock, so the programmed M can be checked at a slow, host-controlled rate. Changes of M and of the output code are held back until the divider concerned reaches its terminal count, so a reprogram never shortens a phase that is already in progress.

Top module: `synth_divchain`

## Requirements
- R1: `ref_clk` is the crystal clock divided by REF_DIV (16) with 50% duty: 8 crystal cycles high, then 8 low.
- R2: `fb_clk` toggles once every M VCO cycles, where M is the plain binary value of `m_val` (bit 8 weighs 256, bit 0 weighs 1). This gives a period of 2·M VCO cycles.
- R3: An `m_val` of 0 or 1 acts as 2, so `fb_clk` holds each level for exactly 2 VCO cycles and never stalls.
- R4: A new `m_val` is taken only when the divider reloads. A half period of `fb_clk` already under way completes with the old M, and the next one uses the new M.
- R5: `n_code` picks the output ratio: 00 gives ÷2, 01 gives ÷4, 10 gives ÷8, and 11 gives ÷1. For the divided codes, `out_clk` is high and low for equal numbers of VCO cycles.
- R6: A new `n_code` takes effect only when the 5-bit output counter wraps from all ones to zero. An output phase already under way keeps its old length.
- R7: With code 11, `out_clk` follows `vco_clk`. The mux select changes only on a falling VCO edge, so the switch never produces a runt pulse.
- R8: `t_sel` picks the test output: 000 gives `sr_out`, 001 gives constant 1, 010 gives `ref_clk`, 011 gives `fb_clk`, 100 gives `out_clk`, and 101 gives constant 0.
- R9: `t_sel` 110 gives the serial clock divided by M and then halved. Each level lasts M serial clock cycles, with the same clamp and reload rule as R3 and R4.
- R10: `t_sel` 111 gives the output clock divided by 4. Each level lasts 2·N VCO cycles, where N is the ratio chosen by R5.
- R11: While `rst_n` is low, `ref_clk`, `fb_clk`, `out_clk` and the serial-clock divider output are all 0, and the applied output code is 00 (÷2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Crystal clock |
| vco_clk | input | 1 | VCO clock, modelled as a digital clock |
| sclk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| m_val | input | 9 | Feedback divide ratio M |
| n_code | input | 2 | Output divider code |
| t_sel | input | 3 | Test output select |
| sr_out | input | 1 | Serial output of the external shift register |
| ref_clk | output | 1 | Phase-detector reference clock |
| fb_clk | output | 1 | Halved feedback clock (VCO ÷ M ÷ 2) |
| out_clk | output | 1 | Synthesizer output clock |
| test_out | output | 1 | Selected test signal |

## Verification
A wrong reload value in a divider shows up as a wrong level length on `fb_clk`, on `ref_clk` or on the test pin, within one half period of the affected clock. That is at most 511 cycles of its own clock. A bad output-code decode or tap choice changes the `out_clk` level lengths within 32 VCO cycles of the code being applied. A select that switches at the wrong time shows up in the very first phase measured after a reprogram, because that phase no longer keeps its old length. A mis-wired test selector is visible as soon as the select changes.

// File: rtl/synth_divchain_pkg.sv
package synth_divchain_pkg;
   localparam int N_W     = 2;
   localparam int T_W     = 3;
   localparam int OCNT_W  = 5;

   typedef enum logic [T_W-1:0] {
      TS_SHIFT  = 3'b000,
      TS_ONE    = 3'b001,
      TS_REF    = 3'b010,
      TS_FB     = 3'b011,
      TS_OUT    = 3'b100,
      TS_ZERO   = 3'b101,
      TS_SCLK_M = 3'b110,
      TS_QUART  = 3'b111
   } tsel_e;

   localparam logic [N_W-1:0] NC_BYPASS = 2'b11;

   // counter bit that carries the divided output for a code
   function automatic logic [2:0] out_tap(input logic [N_W-1:0] code);
      return (code == NC_BYPASS) ? 3'd0 : {1'b0, code};
   endfunction

   // counter bit that carries the output divided by four
   function automatic logic [2:0] quarter_tap(input logic [N_W-1:0] code);
      return (code == NC_BYPASS) ? 3'd1 : ({1'b0, code} + 3'd2);
   endfunction
endpackage

// File: rtl/sd_ref_div.sv
module sd_ref_div #(
   parameter int RATIO = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic ref_o
);
   localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;

   generate
      if (RATIO < 2 || (RATIO & (RATIO - 1)) != 0) begin : g_bad_ratio
         $error("sd_ref_div: RATIO must be a power of two of at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   assign ref_o = cnt[CW-1];
endmodule

// File: rtl/sd_m_div.sv
module sd_m_div #(
   parameter int MW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [MW-1:0] m_i,
   output logic          half_o
);
   generate
      if (MW < 2) begin : g_bad_mw
         $error("sd_m_div: MW must be at least 2");
      end
   endgenerate

   localparam logic [MW-1:0] M_MIN = MW'(2);

   logic [MW-1:0] cnt;
   logic [MW-1:0] m_eff;
   logic          tog;

   always_comb m_eff = (m_i < M_MIN) ? M_MIN : m_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         tog <= 1'b0;
      end else if (cnt == '0) begin
         cnt <= m_eff - 1'b1;
         tog <= ~tog;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   assign half_o = tog;
endmodule

// File: rtl/sd_out_div.sv
module sd_out_div
   import synth_divchain_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_W-1:0]    code_i,
   output logic              out_o,
   output logic              quarter_o,
   output logic [N_W-1:0]    code_app_o,
   output logic [OCNT_W-1:0] cnt_o
);
   logic [OCNT_W-1:0] cnt;
   logic [N_W-1:0]    n_app;
   logic              byp_q;
   logic              div_tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         n_app <= '0;
      end else begin
         cnt <= cnt + 1'b1;
         if (&cnt) n_app <= code_i;
      end
   end

   // select of the clock mux moves only while clk is low
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) byp_q <= 1'b0;
      else        byp_q <= (n_app == NC_BYPASS);
   end

   always_comb begin
      div_tap   = cnt[out_tap(n_app)];
      quarter_o = cnt[quarter_tap(n_app)];
   end

   assign out_o      = byp_q ? clk : div_tap;
   assign code_app_o = n_app;
   assign cnt_o      = cnt;
endmodule

// File: rtl/synth_divchain.sv
module synth_divchain
   import synth_divchain_pkg::*;
#(
   parameter int REF_DIV = 16,
   parameter int M_W     = 9
) (
   input  logic           xtal_clk,
   input  logic           vco_clk,
   input  logic           sclk,
   input  logic           rst_n,
   input  logic [M_W-1:0] m_val,
   input  logic [1:0]     n_code,
   input  logic [2:0]     t_sel,
   input  logic           sr_out,
   output logic           ref_clk,
   output logic           fb_clk,
   output logic           out_clk,
   output logic           test_out
);
   logic              sclk_half;
   logic              quarter;
   logic [N_W-1:0]    n_app;
   logic [OCNT_W-1:0] ocnt;

   sd_ref_div #(.RATIO(REF_DIV)) u_ref (
      .clk(xtal_clk), .rst_n(rst_n), .ref_o(ref_clk)
   );

   sd_m_div #(.MW(M_W)) u_fb (
      .clk(vco_clk), .rst_n(rst_n), .m_i(m_val), .half_o(fb_clk)
   );

   sd_m_div #(.MW(M_W)) u_sfb (
      .clk(sclk), .rst_n(rst_n), .m_i(m_val), .half_o(sclk_half)
   );

   sd_out_div u_out (
      .clk(vco_clk), .rst_n(rst_n), .code_i(n_code),
      .out_o(out_clk), .quarter_o(quarter),
      .code_app_o(n_app), .cnt_o(ocnt)
   );

   always_comb begin
      unique case (tsel_e'(t_sel))
         TS_SHIFT:  test_out = sr_out;
         TS_ONE:    test_out = 1'b1;
         TS_REF:    test_out = ref_clk;
         TS_FB:     test_out = fb_clk;
         TS_OUT:    test_out = out_clk;
         TS_ZERO:   test_out = 1'b0;
         TS_SCLK_M: test_out = sclk_half;
         TS_QUART:  test_out = quarter;
         default:   test_out = 1'b0;
      endcase
   end
endmodule

// File: rtl/synth_divchain_chk.sv
module synth_divchain_chk #(
   parameter int REF_DIV = 16
) (
   input logic       xtal_clk,
   input logic       vco_clk,
   input logic       rst_n,
   input logic       ref_clk,
   input logic       fb_clk,
   input logic [2:0] t_sel,
   input logic       sr_out,
   input logic       test_out,
   input logic [1:0] n_app,
   input logic [4:0] ocnt
);
   localparam int HALF = REF_DIV / 2;

   logic [15:0] ref_run;
   logic        ref_prev;

   always_ff @(posedge xtal_clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_run  <= '0;
         ref_prev <= 1'b0;
      end else begin
         ref_prev <= ref_clk;
         ref_run  <= (ref_clk != ref_prev) ? 16'd0 : ref_run + 16'd1;
      end
   end

   // R1: reference level never outlasts half the ratio
   assert_ref_level_R1: assert property (@(posedge xtal_clk) disable iff (!rst_n)
      ref_run <= 16'(HALF));

   // R3: feedback level lasts at least two VCO cycles
   assert_fb_min_hold_R3: assert property (@(posedge vco_clk) disable iff (!rst_n)
      !$stable(fb_clk) |=> $stable(fb_clk));

   // R6: applied output code moves only at counter wrap
   assert_ncode_at_wrap_R6: assert property (@(posedge vco_clk) disable iff (!rst_n)
      !$stable(n_app) |-> (ocnt == 5'd0));

   // R8: constant and pass-through selections
   assert_test_high_R8: assert property (@(posedge vco_clk) disable iff (!rst_n)
      (t_sel == 3'b001) |-> test_out);
   assert_test_low_R8: assert property (@(posedge vco_clk) disable iff (!rst_n)
      (t_sel == 3'b101) |-> !test_out);
   assert_test_shift_R8: assert property (@(posedge vco_clk) disable iff (!rst_n)
      (t_sel == 3'b000) |-> (test_out == sr_out));
endmodule

bind synth_divchain synth_divchain_chk #(.REF_DIV(REF_DIV)) u_chk (
   .xtal_clk(xtal_clk), .vco_clk(vco_clk), .rst_n(rst_n),
   .ref_clk(ref_clk), .fb_clk(fb_clk), .t_sel(t_sel), .sr_out(sr_out),
   .test_out(test_out), .n_app(n_app), .ocnt(ocnt)
);

// File: tb/synth_divchain_tb.sv
`timescale 1ns/1ps
module synth_divchain_tb;
   localparam int VCO_PERIOD  = 4;
   localparam int XTAL_HALF   = 5;
   localparam int SCLK_HALF   = 7;
   localparam int DOM_VCO = 0, DOM_XTAL = 1, DOM_SCLK = 2;

   logic       xtal_clk = 0, vco_clk = 0, sclk = 0, rst_n = 0;
   logic [8:0] m_val = 9'd100;
   logic [1:0] n_code = 2'b00;
   logic [2:0] t_sel = 3'b110;
   logic       sr_out = 0;
   logic       ref_clk, fb_clk, out_clk, test_out;

   int tests = 0, fails = 0;
   bit done = 0;

   always #(VCO_PERIOD/2) vco_clk = ~vco_clk;
   always #(XTAL_HALF)    xtal_clk = ~xtal_clk;
   always #(SCLK_HALF)    sclk = ~sclk;

   synth_divchain u_dut (
      .xtal_clk(xtal_clk), .vco_clk(vco_clk), .sclk(sclk), .rst_n(rst_n),
      .m_val(m_val), .n_code(n_code), .t_sel(t_sel), .sr_out(sr_out),
      .ref_clk(ref_clk), .fb_clk(fb_clk), .out_clk(out_clk), .test_out(test_out)
   );

   function automatic int fb_half(input int m);
      return (m < 2) ? 2 : m;
   endfunction
   function automatic int n_ratio(input logic [1:0] c);
      case (c) 2'b00: return 2; 2'b01: return 4; 2'b10: return 8; default: return 1; endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int dom);
      case (dom)
         DOM_VCO:  @(negedge vco_clk);
         DOM_XTAL: @(negedge xtal_clk);
         default:  @(negedge sclk);
      endcase
   endtask

   task automatic vco_wait(input int n);
      for (int i = 0; i < n; i++) @(negedge vco_clk);
   endtask

   task automatic wait_rise(input int dom);
      do tick(dom); while (test_out == 1'b1);
      do tick(dom); while (test_out == 1'b0);
   endtask

   task automatic count_level(input int dom, input logic lvl, output int n);
      n = 1;
      forever begin
         tick(dom);
         if (test_out != lvl) break;
         n++;
      end
   endtask

   task automatic measure(input int dom, output int hi, output int lo);
      int d;
      wait_rise(dom);
      count_level(dom, 1'b1, hi);
      count_level(dom, 1'b0, lo);
      d = hi;
   endtask

   task automatic route(input logic [2:0] s);
      @(negedge vco_clk);
      t_sel = s;
   endtask

   initial begin
      int hi, lo, m, old_m;
      logic [1:0] c;
      void'($urandom(32'd1977));

      vco_wait(5);
      // R11: reset state
      chk("R11 ref_clk", ref_clk, 0);
      chk("R11 fb_clk", fb_clk, 0);
      chk("R11 out_clk", out_clk, 0);
      chk("R11 sclk path", test_out, 0);
      @(negedge vco_clk); rst_n = 1;

      // R1: reference divider
      route(3'b010);
      measure(DOM_XTAL, hi, lo);
      chk("R1 ref high", hi, 8);
      chk("R1 ref low", lo, 8);

      // R2: directed M at lock range ends
      route(3'b011);
      foreach (m_val[i]) ;
      for (int k = 0; k < 2; k++) begin
         @(negedge vco_clk); m_val = (k == 0) ? 9'd100 : 9'd350;
         vco_wait(800);
         measure(DOM_VCO, hi, lo);
         chk("R2 fb high", hi, m_val);
         chk("R2 fb low", lo, m_val);
      end

      // R3: clamp of 0 and 1
      for (int k = 0; k < 2; k++) begin
         @(negedge vco_clk); m_val = 9'(k);
         vco_wait(800);
         measure(DOM_VCO, hi, lo);
         chk("R3 clamp high", hi, 2);
         chk("R3 clamp low", lo, 2);
      end

      // R2: random M and N
      for (int k = 0; k < 6; k++) begin
         m = 2 + ($urandom % 359);
         c = 2'($urandom % 3);
         @(negedge vco_clk); m_val = 9'(m); n_code = c;
         vco_wait(800);
         route(3'b011);
         measure(DOM_VCO, hi, lo);
         chk("R2 random fb high", hi, fb_half(m));
         chk("R2 random fb low", lo, fb_half(m));
         route(3'b100);
         measure(DOM_VCO, hi, lo);
         chk("R5 random out high", hi, n_ratio(c) / 2);
         chk("R5 random out low", lo, n_ratio(c) / 2);
      end

      // R4: change M inside a phase
      route(3'b011);
      @(negedge vco_clk); m_val = 9'd20;
      vco_wait(800);
      wait_rise(DOM_VCO);
      old_m = 20;
      m_val = 9'd7;
      count_level(DOM_VCO, 1'b1, hi);
      count_level(DOM_VCO, 1'b0, lo);
      chk("R4 phase keeps old M", hi, old_m);
      chk("R4 next phase new M", lo, 7);

      // R5: each divided code, and R10 quarter rate
      for (int k = 0; k < 4; k++) begin
         c = 2'(k);
         @(negedge vco_clk); n_code = c;
         vco_wait(40);
         if (c != 2'b11) begin
            route(3'b100);
            measure(DOM_VCO, hi, lo);
            chk("R5 out high", hi, n_ratio(c) / 2);
            chk("R5 out low", lo, n_ratio(c) / 2);
         end
         route(3'b111);
         measure(DOM_VCO, hi, lo);
         chk("R10 quarter high", hi, 2 * n_ratio(c));
         chk("R10 quarter low", lo, 2 * n_ratio(c));
      end

      // R7: bypass follows vco_clk
      for (int k = 0; k < 3; k++) begin
         @(posedge vco_clk); #1;
         chk("R7 out high with vco", out_clk, 1);
         @(negedge vco_clk); #1;
         chk("R7 out low with vco", out_clk, 0);
      end

      // R6: code change waits for counter wrap
      @(negedge vco_clk); n_code = 2'b10;
      vco_wait(40);
      route(3'b100);
      wait_rise(DOM_VCO);
      n_code = 2'b00;
      count_level(DOM_VCO, 1'b1, hi);
      chk("R6 phase keeps old code", hi, 4);
      vco_wait(40);
      measure(DOM_VCO, hi, lo);
      chk("R6 new code applied", hi, 1);

      // R8: constants and shift-register path
      route(3'b001); @(posedge vco_clk); #1;
      chk("R8 const high", test_out, 1);
      route(3'b101); @(posedge vco_clk); #1;
      chk("R8 const low", test_out, 0);
      route(3'b000);
      sr_out = 1; #1;
      chk("R8 shift out 1", test_out, 1);
      @(negedge vco_clk); sr_out = 0; #1;
      chk("R8 shift out 0", test_out, 0);

      // R9: serial clock through M divider
      @(negedge vco_clk); m_val = 9'd5; t_sel = 3'b110;
      repeat (30) @(negedge sclk);
      measure(DOM_SCLK, hi, lo);
      chk("R9 sclk/M high", hi, 5);
      chk("R9 sclk/M low", lo, 5);
      @(negedge vco_clk); m_val = 9'd1;
      repeat (30) @(negedge sclk);
      measure(DOM_SCLK, hi, lo);
      chk("R9 sclk clamp high", hi, 2);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(VCO_PERIOD * 150000);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule